// File: doc/BRIEF.md
# Reduced-Instruction Boundary-Scan Test Port

This block is the serial test port of a memory device. A four-wire serial interface (test clock, mode select, data in, data out) drives the standard sixteen-state test-port state machine. That machine moves serial data through one of four registers: a 3-bit instruction register, a 1-bit bypass register, a 32-bit identification register, or a 69-bit boundary register. The boundary register snapshots a parallel input that carries the state of the device's pin ring.

The instruction set is deliberately reduced. All three boundary instructions only capture the pin ring and shift it out. No preload path exists, and the Update-DR state never writes boundary cells back to the pins. Two of the boundary instructions also raise a flag that tells the functional core to place its outputs in high impedance.

The serial pins carry one bit per test-clock edge with no flow control. There is therefore no valid/ready handshake, and the port never applies back-pressure: the state machine alone decides when a bit is consumed or produced.

Top module: `scan_tap`

## Requirements
- R1: The mode-select and data-in pins are sampled on the rising test-clock edge. Five consecutive rising edges with mode-select high bring the state machine to Test-Logic-Reset from any state, and that state makes 001 the active instruction.
- R2: After reset the active instruction is 001 (identification), the data-out enable is low and the high-impedance flag is low.
- R3: In Capture-IR the instruction shift register loads 3'b001: the two low bits take the pattern 01 and the top bit takes 0. Shifting it out yields 1, 0, 0 on data-out.
- R4: A shifted instruction becomes active only on leaving Update-IR. The active instruction is held unchanged during Shift-IR and in every other state except Update-IR and Test-Logic-Reset.
- R5: Instruction decode: 000, 010 and 100 select the 69-bit boundary register; 001 selects the 32-bit identification register; 111 and the unused codes 011, 101 and 110 select the 1-bit bypass register.
- R6: The high-impedance flag is high exactly while the active instruction is 000 or 010.
- R7: With a boundary instruction active, Capture-DR loads the 69-bit ring input, and bit 0 of the ring leaves first. Update-DR changes neither the high-impedance flag nor the next captured value.
- R8: The identification word has bit 0 = 1, bits 11:1 = manufacturer field, bits 28:12 = device field, and bits 31:29 = revision field. Capture-DR loads it when instruction 001 is active.
- R9: The bypass register is cleared to 0 in Capture-DR. Its data-out is that 0 followed by data-in delayed by one shift.
- R10: During Shift-IR and Shift-DR, data-in enters the MSB of the selected register and its LSB drives data-out. After as many shifts as the register is long, the first bit shifted in appears at data-out.
- R11: Data-out and its enable change only on the falling test-clock edge. The enable is high only while the state is Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | Drive enable for tdo, high only while shifting |
| ring_in | input | 69 | Parallel pin-ring snapshot captured into the boundary register |
| force_hiz | output | 1 | Request to the core to tri-state its outputs |

## Verification
The hardest condition to reach from the pins is the forced return to Test-Logic-Reset from arbitrary states. Some of those states, such as the pause and exit states, are entered only through specific mode-select histories. The stimulus first loads a boundary instruction that raises the high-impedance flag. It then walks the machine through sixteen different prefix lengths of a fixed mode-select pattern, applies five high bits, and checks that the flag has dropped and the identification word reads back. Every one of the eight instruction codes is also swept with two ring patterns. The expected serial stream is computed as the captured value followed by the delayed input stream.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  localparam int IR_W = 3;
  typedef logic [IR_W-1:0] instr_t;

  localparam instr_t OP_EXTEST  = 3'b000;
  localparam instr_t OP_IDCODE  = 3'b001;
  localparam instr_t OP_SAMPLEZ = 3'b010;
  localparam instr_t OP_SAMPLE  = 3'b100;
  localparam instr_t OP_BYPASS  = 3'b111;

  localparam instr_t IR_CAPTURE = instr_t'(2'b01);

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} path_t;

  function automatic path_t path_of(instr_t op);
    case (op)
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: return PATH_BSR;
      OP_IDCODE:                        return PATH_ID;
      default:                          return PATH_BYP;
    endcase
  endfunction

  function automatic logic drives_hiz(instr_t op);
    return (op == OP_EXTEST) || (op == OP_SAMPLEZ);
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;

  // run length of high mode-select samples, saturating at the escape length
  localparam int ESC_LEN = 5;
  localparam int ESC_W   = $clog2(ESC_LEN + 1);
  logic [ESC_W-1:0] ones_run;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)                         ones_run <= '0;
    else if (!tms)                      ones_run <= '0;
    else if (ones_run < ESC_W'(ESC_LEN)) ones_run <= ones_run + 1'b1;

  assert_escape_reset_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_run >= ESC_W'(ESC_LEN)) |-> (state == ST_RESET));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_t state,
  output instr_t     ir_q,
  output logic       ir_lsb
);

  instr_t sr;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) begin
      sr   <= IR_CAPTURE;
      ir_q <= OP_IDCODE;
    end else begin
      case (state)
        ST_CAP_IR: sr <= IR_CAPTURE;
        ST_SH_IR:  sr <= {tdi, sr[IR_W-1:1]};
        default:   ;
      endcase
      if (state == ST_RESET)       ir_q <= OP_IDCODE;
      else if (state == ST_UPD_IR) ir_q <= sr;
    end

  assign ir_lsb = sr[0];

  assert_ir_hold_R4: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_q));

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (sr == IR_CAPTURE));

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int          BSR_W  = 69,
  parameter int          ID_W   = 32,
  parameter logic [ID_W-1:0] ID_WORD = '1
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tdi,
  input  tap_state_t       state,
  input  path_t            path,
  input  logic [BSR_W-1:0] ring_in,
  output logic             dr_lsb
);

  logic             byp;
  logic [ID_W-1:0]  id_sr;
  logic [BSR_W-1:0] bsr;

  logic cap, sh;
  assign cap = (state == ST_CAP_DR);
  assign sh  = (state == ST_SH_DR);

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) byp <= 1'b0;
    else if (path == PATH_BYP) begin
      if (cap)     byp <= 1'b0;
      else if (sh) byp <= tdi;
    end

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) id_sr <= ID_WORD;
    else if (path == PATH_ID) begin
      if (cap)     id_sr <= ID_WORD;
      else if (sh) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

  // Update-DR leaves the boundary cells alone: there is no preload stage
  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) bsr <= '0;
    else if (path == PATH_BSR) begin
      if (cap)     bsr <= ring_in;
      else if (sh) bsr <= {tdi, bsr[BSR_W-1:1]};
    end

  always_comb
    case (path)
      PATH_ID:  dr_lsb = id_sr[0];
      PATH_BSR: dr_lsb = bsr[0];
      default:  dr_lsb = byp;
    endcase

  assert_bypass_clear_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && path == PATH_BYP) |=> (byp == 1'b0));

  assert_id_capture_R8: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && path == PATH_ID) |=> (id_sr[0] == 1'b1));

  assert_bsr_capture_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && path == PATH_BSR) |=> (bsr == $past(ring_in)));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          BSR_W   = 69,
  parameter logic [2:0]  ID_REV  = 3'b001,
  parameter logic [16:0] ID_PART = 17'h0B226,
  parameter logic [10:0] ID_MFR  = 11'h034
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  input  logic [BSR_W-1:0] ring_in,
  output logic             force_hiz
);

  localparam int ID_W = $bits(ID_REV) + $bits(ID_PART) + $bits(ID_MFR) + 1;
  localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_PART, ID_MFR, 1'b1};

  tap_state_t state;
  instr_t     ir_q;
  logic       ir_lsb, dr_lsb;
  path_t      path;

  scan_tap_fsm i_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

  scan_tap_ir i_ir (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state),
    .ir_q(ir_q), .ir_lsb(ir_lsb)
  );

  assign path = path_of(ir_q);

  scan_tap_dr #(.BSR_W(BSR_W), .ID_W(ID_W), .ID_WORD(ID_WORD)) i_dr (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state), .path(path),
    .ring_in(ring_in), .dr_lsb(dr_lsb)
  );

  assign force_hiz = drives_hiz(ir_q);

  // serial output retimed to the falling edge
  always_ff @(negedge tck or negedge rst_n)
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
      tdo    <= (state == ST_SH_IR) ? ir_lsb :
                (state == ST_SH_DR) ? dr_lsb : 1'b0;
    end

  assert_tdo_en_shift_R11: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

  assert_hiz_after_update_R6: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(force_hiz) |-> ($past(state) == ST_UPD_IR));

endmodule

// File: tb/test_scan_tap.sv
module test_scan_tap;

  localparam int RING = 69;
  localparam logic [2:0]  REV  = 3'b101;
  localparam logic [16:0] PART = 17'h1A5C3;
  localparam logic [10:0] MFR  = 11'h2B7;
  localparam logic [31:0] IDW  = {REV, PART, MFR, 1'b1};
  localparam int EXTRA = 8;

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [RING-1:0] ring = '0;
  logic tdo, tdo_en, force_hiz;

  always #5 tck = ~tck;

  scan_tap #(.BSR_W(RING), .ID_REV(REV), .ID_PART(PART), .ID_MFR(MFR)) i_scan_tap (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .ring_in(ring), .force_hiz(force_hiz)
  );

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  logic last_en;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one test-clock cycle: sample outputs after the falling edge, then drive
  task automatic tick(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo; last_en = tdo_en;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic step(input logic m);
    logic o;
    tick(m, 1'b0, o);
  endtask

  // from Run-Test/Idle: load an instruction, return the captured IR bits
  task automatic load_ir(input logic [2:0] code, input bit exp_hiz,
                         output logic [2:0] cap);
    logic o;
    logic old_hiz;
    bit held;
    old_hiz = force_hiz;
    held = 1'b1;
    step(1); step(1); step(0); step(0);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i], o);
      cap[i] = o;
      if (force_hiz !== old_hiz) held = 1'b0;
    end
    step(1);
    if (force_hiz !== old_hiz) held = 1'b0;
    check(held, "R4 instruction held until Update-IR", 128'(force_hiz), 128'(old_hiz));
    step(0);
    check(force_hiz === exp_hiz, "R4/R6 instruction active after Update-IR",
          128'(force_hiz), 128'(exp_hiz));
  endtask

  // from Run-Test/Idle: capture and shift len bits, return what came out
  task automatic shift_dr(input int len, input logic [127:0] din,
                          output logic [127:0] dout, output bit en_ok, output bit fe_ok);
    logic o;
    en_ok = 1'b1; fe_ok = 1'b1;
    dout = '0;
    step(1); step(0); step(0);
    for (int i = 0; i < len; i++) begin
      tick(i == len - 1, din[i], o);
      dout[i] = o;
      if (last_en !== 1'b1) en_ok = 1'b0;
      if (tdo !== o) fe_ok = 1'b0;   // still old bit just after the rising edge
    end
    step(1); step(0);
  endtask

  function automatic logic [127:0] expect_stream(input int reg_len, input logic [127:0] cap,
                                                 input logic [127:0] din, input int len);
    logic [127:0] e;
    e = '0;
    for (int j = 0; j < len; j++) e[j] = (j < reg_len) ? cap[j] : din[j - reg_len];
    return e;
  endfunction

  initial begin
    logic [127:0] dout, exp, din;
    logic [2:0] cap;
    bit en_ok, fe_ok;
    int rlen, len;
    logic [127:0] cval;
    logic [15:0] walk;

    repeat (3) @(posedge tck);
    #2 rst_n = 1'b1;
    #1;
    check(tdo_en === 1'b0, "R2 data-out enable low after reset", 128'(tdo_en), 0);
    check(force_hiz === 1'b0, "R2 high-impedance flag low after reset", 128'(force_hiz), 0);

    step(0);  // to Run-Test/Idle
    din = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    shift_dr(40, din, dout, en_ok, fe_ok);
    exp = expect_stream(32, 128'(IDW), din, 40);
    check(dout[39:0] === exp[39:0], "R2/R8 identification after reset", dout, exp);
    check(en_ok, "R11 enable high while shifting", 0, 1);
    check(fe_ok, "R11 data-out changes on falling edge", 0, 1);
    check(tdo_en === 1'b0, "R11 enable low outside shift", 128'(tdo_en), 0);

    // sweep every instruction code with two ring patterns
    for (int code = 0; code < 8; code++) begin
      bit hz;
      hz = (code == 0) || (code == 2);
      load_ir(3'(code), hz, cap);
      check(cap === 3'b001, "R3 Capture-IR pattern", 128'(cap), 128'(3'b001));
      for (int p = 0; p < 2; p++) begin
        ring = {5'(code * 3 + p), 64'h9E37_79B9_7F4A_7C15 ^ (64'(code + 1) << (p * 7))};
        din  = {64'hC3A5_5A3C_0FF0_1234, 64'h8421_4218_2184_1842} ^ 128'(code * 97 + p);
        if (code == 0 || code == 2 || code == 4) begin
          rlen = RING; cval = 128'(ring);
        end else if (code == 1) begin
          rlen = 32; cval = 128'(IDW);
        end else begin
          rlen = 1; cval = '0;
        end
        len = rlen + EXTRA;
        shift_dr(len, din, dout, en_ok, fe_ok);
        exp = expect_stream(rlen, cval, din, len);
        if (rlen == RING)
          check(dout === exp, "R5/R7/R10 boundary capture and shift", dout, exp);
        else if (rlen == 32)
          check(dout === exp, "R5/R8/R10 identification shift", dout, exp);
        else
          check(dout === exp, "R5/R9/R10 bypass shift", dout, exp);
        check(en_ok && fe_ok, "R11 shift output timing", 128'({en_ok, fe_ok}), 128'(2'b11));
        check(force_hiz === hz, "R6/R7 flag unchanged by Update-DR", 128'(force_hiz), 128'(hz));
      end
    end

    // escape to Test-Logic-Reset from states reached by different walks
    walk = 16'b0110_1001_1101_0110;
    for (int k = 0; k < 16; k++) begin
      load_ir(3'b000, 1'b1, cap);
      for (int s = 0; s < k; s++) step(walk[s]);
      repeat (5) step(1);
      check(force_hiz === 1'b0, "R1 five high mode-select bits reset instruction",
            128'(force_hiz), 0);
      step(0);
      din = 128'(k * 1234567);
      shift_dr(34, din, dout, en_ok, fe_ok);
      exp = expect_stream(32, 128'(IDW), din, 34);
      check(dout[33:0] === exp[33:0], "R1 identification selected after escape", dout, exp);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule